// File: doc/BRIEF.md
# Tri-Port Bus Exchanger

The block connects three 16-bit bidirectional data ports, A, B and C. Each port owns a storage stage that can follow its input live, hold its contents, or take a new value on a rising edge of that port's capture strobe when its clock enable is asserted. Each port can drive onto its pins the stored value of one of the two other ports. A per-port select input picks which one, and an active-low output enable turns the drive on or off. With suitable selects, one port's input can reach either of the other ports, or both at the same time.

Each bidirectional pin group appears as three separate vectors: incoming data, outgoing data and a per-bit drive enable. All three storage stages run on one shared system clock. Each port's strobe is sampled on that clock, and a rising edge on the strobe is detected by comparing it with its value one cycle earlier. Transparent mode is a combinational bypass around the stored register. The register keeps tracking the input while the bypass is open, so when the latch enable drops, the last value seen stays in place.

Top module: `xchg_tri_port`

## Requirements
- R1: While a port's latch enable is high, that port's stored value, as seen on any port routing it, equals the port's live input data in the same cycle.
- R2: With the latch enable low and the active-low clock enable low, a port captures its input data at a system clock edge where its strobe is sampled high and was sampled low one cycle earlier.
- R3: With the latch enable low, the stored value does not change while the strobe stays high or stays low, or while the clock enable is high (inactive), even when the strobe rises.
- R4: When a port's latch enable goes from high to low, the stored value is the input data sampled at the last clock edge at which the latch enable was still high.
- R5: A port's output enable is active low. When it is high (1), every drive-enable bit of that port is 0 and its output data is all zeros. When it is low (0), every drive-enable bit is 1.
- R6: Port A outputs the stored C value when its select is 1 and the stored B value when its select is 0.
- R7: Port B outputs the stored A value when its select is 1 and the stored C value when its select is 0.
- R8: Port C outputs the stored B value when its select is 1 and the stored A value when its select is 0.
- R9: One port's stored value can be driven on both other ports in the same cycle (B with select 1 and C with select 0 both show A).
- R10: A synchronous active-high reset clears all three stored values to zero and clears the strobe edge detectors to the low state.
- R11: A port's storage takes data only from its own input vector and never from its own output vector, even while that port is driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared system clock |
| rst | input | 1 | Synchronous active-high reset |
| a_din | input | 16 | Port A incoming data |
| a_le | input | 1 | Port A latch enable (transparent when 1) |
| a_cen_n | input | 1 | Port A clock enable, active low |
| a_tck | input | 1 | Port A capture strobe, sampled on clk |
| a_sel | input | 1 | Port A source select |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_dout | output | 16 | Port A outgoing data |
| a_drv | output | 16 | Port A per-bit drive enable |
| b_din | input | 16 | Port B incoming data |
| b_le | input | 1 | Port B latch enable |
| b_cen_n | input | 1 | Port B clock enable, active low |
| b_tck | input | 1 | Port B capture strobe |
| b_sel | input | 1 | Port B source select |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_dout | output | 16 | Port B outgoing data |
| b_drv | output | 16 | Port B per-bit drive enable |
| c_din | input | 16 | Port C incoming data |
| c_le | input | 1 | Port C latch enable |
| c_cen_n | input | 1 | Port C clock enable, active low |
| c_tck | input | 1 | Port C capture strobe |
| c_sel | input | 1 | Port C source select |
| c_oe_n | input | 1 | Port C output enable, active low |
| c_dout | output | 16 | Port C outgoing data |
| c_drv | output | 16 | Port C per-bit drive enable |

## Verification
The assertions assume that every control input and the strobes change only between system clock edges and are steady at each edge. A strobe edge counts only through its sampled history. The stimulus meets this by changing all inputs on the falling clock edge, so each level is held through the next rising edge. Latch enables are kept low most of the time in the sweep, and reset is applied now and then, so that capture, hold and release sequences all occur often between resets.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int XCHG_PORTS = 3;

  // Source picked when a port's select is 1: the port two places ahead.
  function automatic int src_when_high(input int idx);
    return (idx + 2) % XCHG_PORTS;
  endfunction

  // Source picked when a port's select is 0: the next port along.
  function automatic int src_when_low(input int idx);
    return (idx + 1) % XCHG_PORTS;
  endfunction
endpackage

// File: rtl/xchg_store.sv
module xchg_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le_i,
  input  logic         cen_n_i,
  input  logic         tck_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;
  logic         tck_q;
  logic         edge_cap;

  assign edge_cap = !cen_n_i && tck_i && !tck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      tck_q  <= 1'b0;
    end else begin
      tck_q <= tck_i;
      if (le_i || edge_cap) hold_q <= din_i;
    end
  end

  assign q_o = le_i ? din_i : hold_q;

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!le_i && (cen_n_i || !tck_i || tck_q)) |=> (le_i || $stable(q_o))); // R3
  AST_STORE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!le_i && !cen_n_i && tck_i && !tck_q) |=> (le_i || q_o == $past(din_i))); // R2
  AST_STORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!le_i && $past(le_i) && !$past(rst)) |-> (q_o == $past(din_i))); // R4
  AST_STORE_RESET: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !le_i) |-> (q_o == '0)); // R10
endmodule

// File: rtl/xchg_route.sv
module xchg_route #(
  parameter int W = 16
) (
  input  logic         sel_i,
  input  logic         oe_n_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  output logic [W-1:0] dout_o,
  output logic [W-1:0] drv_o
);
  always_comb begin
    if (oe_n_i) begin
      dout_o = '0;
      drv_o  = '0;
    end else begin
      dout_o = sel_i ? hi_i : lo_i;
      drv_o  = '1;
    end
  end
endmodule

// File: rtl/xchg_tri_port.sv
module xchg_tri_port
  import xchg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_din,
  input  logic         a_le,
  input  logic         a_cen_n,
  input  logic         a_tck,
  input  logic         a_sel,
  input  logic         a_oe_n,
  output logic [W-1:0] a_dout,
  output logic [W-1:0] a_drv,
  input  logic [W-1:0] b_din,
  input  logic         b_le,
  input  logic         b_cen_n,
  input  logic         b_tck,
  input  logic         b_sel,
  input  logic         b_oe_n,
  output logic [W-1:0] b_dout,
  output logic [W-1:0] b_drv,
  input  logic [W-1:0] c_din,
  input  logic         c_le,
  input  logic         c_cen_n,
  input  logic         c_tck,
  input  logic         c_sel,
  input  logic         c_oe_n,
  output logic [W-1:0] c_dout,
  output logic [W-1:0] c_drv
);
  localparam int NP = XCHG_PORTS;

  logic [W-1:0] din  [NP];
  logic [W-1:0] q    [NP];
  logic [W-1:0] dout [NP];
  logic [W-1:0] drv  [NP];
  logic         le   [NP];
  logic         cen_n[NP];
  logic         tck  [NP];
  logic         sel  [NP];
  logic         oe_n [NP];

  assign din[0] = a_din;  assign le[0] = a_le;  assign cen_n[0] = a_cen_n;
  assign tck[0] = a_tck;  assign sel[0] = a_sel; assign oe_n[0] = a_oe_n;
  assign din[1] = b_din;  assign le[1] = b_le;  assign cen_n[1] = b_cen_n;
  assign tck[1] = b_tck;  assign sel[1] = b_sel; assign oe_n[1] = b_oe_n;
  assign din[2] = c_din;  assign le[2] = c_le;  assign cen_n[2] = c_cen_n;
  assign tck[2] = c_tck;  assign sel[2] = c_sel; assign oe_n[2] = c_oe_n;

  assign a_dout = dout[0]; assign a_drv = drv[0];
  assign b_dout = dout[1]; assign b_drv = drv[1];
  assign c_dout = dout[2]; assign c_drv = drv[2];

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int HI = src_when_high(p);
    localparam int LO = src_when_low(p);

    xchg_store #(.W(W)) i_store (
      .clk    (clk),
      .rst    (rst),
      .le_i   (le[p]),
      .cen_n_i(cen_n[p]),
      .tck_i  (tck[p]),
      .din_i  (din[p]),
      .q_o    (q[p])
    );

    xchg_route #(.W(W)) i_route (
      .sel_i (sel[p]),
      .oe_n_i(oe_n[p]),
      .hi_i  (q[HI]),
      .lo_i  (q[LO]),
      .dout_o(dout[p]),
      .drv_o (drv[p])
    );

    AST_ROUTE_HIGH: assert property (@(posedge clk) disable iff (rst)
      (!oe_n[p] && sel[p]) |-> (dout[p] == q[HI] && drv[p] == '1)); // R6, R7, R8
    AST_ROUTE_LOW: assert property (@(posedge clk) disable iff (rst)
      (!oe_n[p] && !sel[p]) |-> (dout[p] == q[LO] && drv[p] == '1)); // R6, R7, R8
    AST_TRISTATE: assert property (@(posedge clk) disable iff (rst)
      oe_n[p] |-> (drv[p] == '0 && dout[p] == '0)); // R5
    AST_OWN_INPUT: assert property (@(posedge clk) disable iff (rst)
      le[p] |-> (q[p] == din[p])); // R11
  end
endmodule

// File: tb/test_xchg_tri_port.sv
module test_xchg_tri_port;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] din[3];
  logic le[3], cen[3], tck[3], sel[3], oen[3];
  logic [W-1:0] dout[3], drv[3];

  logic [W-1:0] mq[3];
  logic         mprev[3];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  xchg_tri_port #(.W(W)) i_xchg_tri_port (
    .clk(clk), .rst(rst),
    .a_din(din[0]), .a_le(le[0]), .a_cen_n(cen[0]), .a_tck(tck[0]),
    .a_sel(sel[0]), .a_oe_n(oen[0]), .a_dout(dout[0]), .a_drv(drv[0]),
    .b_din(din[1]), .b_le(le[1]), .b_cen_n(cen[1]), .b_tck(tck[1]),
    .b_sel(sel[1]), .b_oe_n(oen[1]), .b_dout(dout[1]), .b_drv(drv[1]),
    .c_din(din[2]), .c_le(le[2]), .c_cen_n(cen[2]), .c_tck(tck[2]),
    .c_sel(sel[2]), .c_oe_n(oen[2]), .c_dout(dout[2]), .c_drv(drv[2])
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] eff(input int i);
    return le[i] ? din[i] : mq[i];
  endfunction

  // Model update from the requirements, then one clock edge.
  task automatic advance();
    logic [W-1:0] nq[3];
    logic         np[3];
    for (int i = 0; i < 3; i++) begin
      if (rst) begin
        nq[i] = '0; np[i] = 1'b0;
      end else begin
        nq[i] = (le[i] || (!cen[i] && tck[i] && !mprev[i])) ? din[i] : mq[i];
        np[i] = tck[i];
      end
    end
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      mq[i] = nq[i]; mprev[i] = np[i];
    end
    @(negedge clk);
  endtask

  task automatic check_ports();
    for (int i = 0; i < 3; i++) begin
      logic [W-1:0] ed, ev;
      string tag;
      if (oen[i]) begin
        ed = '0; ev = '0; tag = "R5";
      end else begin
        ed = sel[i] ? eff((i + 2) % 3) : eff((i + 1) % 3);
        ev = '1;
        tag = (i == 0) ? "R6" : (i == 1) ? "R7" : "R8";
      end
      chk(dout[i] == ed, tag, dout[i], ed);
      chk(drv[i] == ev, "R5", drv[i], ev);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      din[i] = '0; le[i] = 1'b0; cen[i] = 1'b1; tck[i] = 1'b0;
      sel[i] = 1'b0; oen[i] = 1'b1; mq[i] = '0; mprev[i] = 1'b0;
    end
    @(negedge clk);
    advance(); advance();
    rst = 1'b0;
    for (int i = 0; i < 3; i++) din[i] = 16'hFFFF;
    advance();
    // R10: stored values cleared
    for (int i = 0; i < 3; i++) oen[i] = 1'b0;
    #1;
    for (int i = 0; i < 3; i++) chk(dout[i] == '0, "R10", dout[i], '0);

    // R1 and R9: A transparent, fanned out to B and C
    din[0] = 16'hA5C3; le[0] = 1'b1; sel[1] = 1'b1; sel[2] = 1'b0; #1;
    chk(dout[1] == 16'hA5C3, "R1", dout[1], 16'hA5C3);
    chk(dout[2] == 16'hA5C3, "R9", dout[2], 16'hA5C3);
    advance();

    // R4: release keeps last transparent value
    le[0] = 1'b0; din[0] = 16'h0F0F; #1;
    chk(dout[1] == 16'hA5C3, "R4", dout[1], 16'hA5C3);
    advance();
    chk(dout[2] == 16'hA5C3, "R4", dout[2], 16'hA5C3);

    // R2: rising strobe with clock enable active
    cen[0] = 1'b0; tck[0] = 1'b1; #1;
    chk(dout[1] == 16'hA5C3, "R2", dout[1], 16'hA5C3);
    advance();
    chk(dout[1] == 16'h0F0F, "R2", dout[1], 16'h0F0F);

    // R3: strobe steady high, then rising edge with clock enable inactive
    din[0] = 16'h1234; advance();
    chk(dout[1] == 16'h0F0F, "R3", dout[1], 16'h0F0F);
    tck[0] = 1'b0; advance();
    chk(dout[1] == 16'h0F0F, "R3", dout[1], 16'h0F0F);
    cen[0] = 1'b1; tck[0] = 1'b1; advance();
    chk(dout[2] == 16'h0F0F, "R3", dout[2], 16'h0F0F);

    // R11: A drives B's value while A stores its own input
    din[1] = 16'h5555; le[1] = 1'b1; sel[0] = 1'b0;
    din[0] = 16'h7777; le[0] = 1'b1; #1;
    chk(dout[0] == 16'h5555, "R6", dout[0], 16'h5555);
    chk(dout[1] == 16'h7777, "R11", dout[1], 16'h7777);
    advance();
    le[0] = 1'b0; le[1] = 1'b0; din[0] = 16'h0000; advance();
    chk(dout[1] == 16'h7777, "R11", dout[1], 16'h7777);

    // Sweep over all routing, enable and storage combinations
    for (int n = 0; n < 6000; n++) begin
      for (int i = 0; i < 3; i++) begin
        din[i] = W'($urandom);
        le[i]  = ($urandom % 5) == 0;
        cen[i] = ($urandom % 3) == 0;
        tck[i] = $urandom % 2;
        sel[i] = $urandom % 2;
        oen[i] = ($urandom % 4) == 0;
      end
      rst = ($urandom % 300) == 0;
      #1;
      check_ports();
      advance();
    end
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule